// File: doc/BRIEF.md
# Configurable LUT Cell Tile

This block is a rectangular tile of identical logic cells for a chaotic cellular automaton. Each cell has one input and one output toward each of its four neighbours. Each output is a 16-entry truth table addressed by the four neighbour inputs. The truth tables are rotated per direction, so one table pattern acts the same way on every side of a cell. The cells on the tile's edges connect to perimeter port vectors, so several tiles can be abutted side by side.

Software, or a loader, writes every truth table through a single serial chain that runs through all cells. The `run` pin separates loading from evaluation. While `run` is low, a shadow copy of each cell's tables follows the chain, and every cell output is held at 0. While `run` is high, the shadow is frozen and the outputs are computed from it, so the chain can be reloaded without disturbing a running pattern. The tile passes its load clock and its serial data on to the next tile, so a string of tiles shares one loader. The serial data path is a raw bit stream clocked on every edge of the load clock. It has no valid/ready handshake and no back-pressure: every edge shifts the chain by one bit.

Top module: `lut_tile`

## Requirements
- R1: Every rising edge of `cfg_clk` shifts the configuration chain by one bit. `cfg_dout` shows the bit that entered at `cfg_din` exactly 64·COLS·ROWS edges earlier.
- R2: The chain visits the cells in row-major order. It starts at row 0 (southmost), column 0 (westmost), and runs eastward along each row. Each row continues from the start of the next row to the north; the direction does not alternate. Within a cell, data enters bit 0 of the north table. North bit 15 feeds east bit 0, east bit 15 feeds south bit 0, south bit 15 feeds west bit 0, and west bit 15 leaves the cell. After a full load, the bit shifted in first occupies the west bit 15 of the last cell.
- R3: With `run` high, each cell output is the table entry at a 4-bit index, with the first-listed input as the MSB. The north output uses {N,E,S,W}. The east output uses {E,S,W,N}. The south output uses {S,W,N,E}. The west output uses {W,N,E,S}.
- R4: While `run` is low, every perimeter output is 0.
- R5: While `run` is high, shifting the chain does not change any output, provided the perimeter inputs are unchanged.
- R6: `arst` (active high) clears every configuration bit asynchronously. `cfg_dout` goes to 0 without waiting for a clock edge.
- R7: `cfg_clk_out` is a copy of `cfg_clk`.
- R8: `north_in`, `north_out`, `south_in` and `south_out` are indexed by column. `east_in`, `east_out`, `west_in` and `west_out` are indexed by row. A cell's output toward a neighbour is that neighbour's input from the opposite side.
- R9: Table value 16'hCCCC makes every output copy the input on the opposite side of its cell. With that value in all tables, each perimeter output equals the input on the opposite edge at the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Load clock for the configuration chain |
| arst | input | 1 | Asynchronous reset, active high |
| run | input | 1 | High: evaluate from frozen shadow; low: shadow follows chain, outputs 0 |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial configuration data out, to the next tile |
| cfg_clk_out | output | 1 | Forwarded load clock |
| north_in | input | COLS | Perimeter inputs into the northern row |
| north_out | output | COLS | Perimeter outputs from the northern row |
| south_in | input | COLS | Perimeter inputs into the southern row |
| south_out | output | COLS | Perimeter outputs from the southern row |
| east_in | input | ROWS | Perimeter inputs into the eastern column |
| east_out | output | ROWS | Perimeter outputs from the eastern column |
| west_in | input | ROWS | Perimeter inputs into the western column |
| west_out | output | ROWS | Perimeter outputs from the western column |

## Verification
The assertions check four behaviours on every cycle. Outputs are zero while `run` is low. Outputs are stable while `run` stays high and the inputs are held. The serial output stays zero until a full chain length has passed after reset. The chain clears as soon as reset is asserted.

Three behaviours can only be shown by the bench's scenarios, because they depend on what was loaded. These are the rotated table addressing, the row-major loading order, and the edge-to-edge wiring. The bench loads feed-forward configurations (opposite-copy, random copy/invert/constant, and two-input diagonal functions) and compares every perimeter output against a behavioural model on every clock.

// File: rtl/lut_tile_pkg.sv
package lut_tile_pkg;
  localparam int TBL_BITS = 16;
  localparam int N_DIR    = 4;
  localparam int CELL_CFG = TBL_BITS * N_DIR;

  // Direction codes; the table offset inside a cell is (N_DIR-1-code)*16.
  typedef enum logic [1:0] {
    DIR_W = 2'd0,
    DIR_S = 2'd1,
    DIR_E = 2'd2,
    DIR_N = 2'd3
  } dir_e;

  typedef struct packed {
    logic n;
    logic e;
    logic s;
    logic w;
  } nbr_t;

  // Index rotated so that the output's own side is the MSB, then clockwise.
  function automatic logic [3:0] lut_addr(nbr_t v, dir_e d);
    case (d)
      DIR_N:   return {v.n, v.e, v.s, v.w};
      DIR_E:   return {v.e, v.s, v.w, v.n};
      DIR_S:   return {v.s, v.w, v.n, v.e};
      default: return {v.w, v.n, v.e, v.s};
    endcase
  endfunction
endpackage

// File: rtl/lut_cfg_chain.sv
module lut_cfg_chain
  import lut_tile_pkg::*;
#(
  parameter int WIDTH = CELL_CFG
) (
  input  logic             clk,
  input  logic             arst,
  input  logic             din,
  output logic [WIDTH-1:0] cfg,
  output logic             dout
);
  logic [WIDTH-1:0] sr_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) sr_q <= '0;
    else      sr_q <= {sr_q[WIDTH-2:0], din};
  end

  assign cfg  = sr_q;
  assign dout = sr_q[WIDTH-1];
endmodule

// File: rtl/lut_eval.sv
module lut_eval
  import lut_tile_pkg::*;
(
  input  logic                run,
  input  logic [CELL_CFG-1:0] cfg,
  input  nbr_t                nb,
  output logic [N_DIR-1:0]    o
);
  logic [CELL_CFG-1:0] shadow;

  // Transparent while loading, frozen while running.
  always_latch begin
    if (!run) shadow = cfg;
  end

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    localparam int   BASE = (N_DIR - 1 - d) * TBL_BITS;
    localparam dir_e DIR  = dir_e'(d);
    logic [TBL_BITS-1:0] tbl;
    assign tbl  = shadow[BASE +: TBL_BITS];
    assign o[d] = run & tbl[lut_addr(nb, DIR)];
  end
endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_tile_pkg::*;
(
  input  logic clk,
  input  logic arst,
  input  logic run,
  input  logic din,
  output logic dout,
  input  logic in_n,
  input  logic in_e,
  input  logic in_s,
  input  logic in_w,
  output logic out_n,
  output logic out_e,
  output logic out_s,
  output logic out_w
);
  logic [CELL_CFG-1:0] cfg;
  logic [N_DIR-1:0]    o;
  nbr_t                nb;

  assign nb = '{n: in_n, e: in_e, s: in_s, w: in_w};

  lut_cfg_chain #(.WIDTH(CELL_CFG)) u_chain (
    .clk (clk),
    .arst(arst),
    .din (din),
    .cfg (cfg),
    .dout(dout)
  );

  lut_eval u_eval (
    .run(run),
    .cfg(cfg),
    .nb (nb),
    .o  (o)
  );

  assign out_n = o[DIR_N];
  assign out_e = o[DIR_E];
  assign out_s = o[DIR_S];
  assign out_w = o[DIR_W];
endmodule

// File: rtl/lut_tile.sv
module lut_tile
  import lut_tile_pkg::*;
#(
  parameter int COLS = 10,
  parameter int ROWS = 10
) (
  input  logic            cfg_clk,
  input  logic            arst,
  input  logic            run,
  input  logic            cfg_din,
  output logic            cfg_dout,
  output logic            cfg_clk_out,
  input  logic [COLS-1:0] north_in,
  output logic [COLS-1:0] north_out,
  input  logic [COLS-1:0] south_in,
  output logic [COLS-1:0] south_out,
  input  logic [ROWS-1:0] east_in,
  output logic [ROWS-1:0] east_out,
  input  logic [ROWS-1:0] west_in,
  output logic [ROWS-1:0] west_out
);
  localparam int CELLS = COLS * ROWS;
  localparam int VBITS = (ROWS + 1) * COLS;
  localparam int HBITS = (COLS + 1) * ROWS;

  // Northbound, southbound, eastbound, westbound links, one slot per boundary.
  logic [VBITS-1:0] up_w;
  logic [VBITS-1:0] dn_w;
  logic [HBITS-1:0] rt_w;
  logic [HBITS-1:0] lt_w;
  logic [CELLS:0]   chain;

  assign up_w[COLS-1:0]          = south_in;
  assign north_out               = up_w[ROWS*COLS +: COLS];
  assign dn_w[ROWS*COLS +: COLS] = north_in;
  assign south_out               = dn_w[COLS-1:0];
  assign rt_w[ROWS-1:0]          = west_in;
  assign east_out                = rt_w[COLS*ROWS +: ROWS];
  assign lt_w[COLS*ROWS +: ROWS] = east_in;
  assign west_out                = lt_w[ROWS-1:0];

  assign chain[0]    = cfg_din;
  assign cfg_dout    = chain[CELLS];
  assign cfg_clk_out = cfg_clk;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int K = r * COLS + c;
      lut_cell u_cell (
        .clk  (cfg_clk),
        .arst (arst),
        .run  (run),
        .din  (chain[K]),
        .dout (chain[K+1]),
        .in_n (dn_w[(r+1)*COLS + c]),
        .in_e (lt_w[(c+1)*ROWS + r]),
        .in_s (up_w[r*COLS + c]),
        .in_w (rt_w[c*ROWS + r]),
        .out_n(up_w[(r+1)*COLS + c]),
        .out_e(rt_w[(c+1)*ROWS + r]),
        .out_s(dn_w[r*COLS + c]),
        .out_w(lt_w[c*ROWS + r])
      );
    end
  end
endmodule

// File: rtl/lut_tile_chk.sv
module lut_tile_chk
  import lut_tile_pkg::*;
#(
  parameter int COLS = 10,
  parameter int ROWS = 10
) (
  input logic            cfg_clk,
  input logic            arst,
  input logic            run,
  input logic            cfg_dout,
  input logic [COLS-1:0] north_in,
  input logic [COLS-1:0] north_out,
  input logic [COLS-1:0] south_in,
  input logic [COLS-1:0] south_out,
  input logic [ROWS-1:0] east_in,
  input logic [ROWS-1:0] east_out,
  input logic [ROWS-1:0] west_in,
  input logic [ROWS-1:0] west_out
);
  localparam int CHAIN_LEN = COLS * ROWS * CELL_CFG;
  localparam int CW        = $clog2(CHAIN_LEN + 1);

  logic [CW-1:0] since_rst;

  always_ff @(posedge cfg_clk or posedge arst) begin
    if (arst)                       since_rst <= '0;
    else if (since_rst < CW'(CHAIN_LEN)) since_rst <= since_rst + 1'b1;
  end

  // R4: gating while loading
  a_r4_zero_when_idle: assert property (@(posedge cfg_clk) disable iff (arst)
    !run |-> (north_out == '0 && south_out == '0 && east_out == '0 && west_out == '0));

  // R5: frozen shadow while running
  a_r5_frozen_outputs: assert property (@(posedge cfg_clk) disable iff (arst)
    (run && $past(run) && $stable(north_in) && $stable(south_in) &&
     $stable(east_in) && $stable(west_in))
    |-> ($stable(north_out) && $stable(south_out) && $stable(east_out) && $stable(west_out)));

  // R1: reset zeros need a full chain length to drain out
  a_r1_drain_length: assert property (@(posedge cfg_clk) disable iff (arst)
    (since_rst < CW'(CHAIN_LEN)) |-> !cfg_dout);

  // R6: asynchronous clear seen at the serial output
  always @(posedge arst) begin
    #1;
    a_r6_async_clear: assert (cfg_dout == 1'b0);
  end
endmodule

bind lut_tile lut_tile_chk #(.COLS(COLS), .ROWS(ROWS)) u_chk (
  .cfg_clk  (cfg_clk),
  .arst     (arst),
  .run      (run),
  .cfg_dout (cfg_dout),
  .north_in (north_in),
  .north_out(north_out),
  .south_in (south_in),
  .south_out(south_out),
  .east_in  (east_in),
  .east_out (east_out),
  .west_in  (west_in),
  .west_out (west_out)
);

// File: tb/lut_tile_tb.sv
`timescale 1ns/1ps
module lut_tile_tb;
  localparam int COLS  = 3;
  localparam int ROWS  = 2;
  localparam int CELLS = COLS * ROWS;
  localparam int L     = CELLS * 64;
  localparam int OW    = 2*COLS + 2*ROWS;

  logic cfg_clk = 1'b0;
  logic arst = 1'b1, run = 1'b0, cfg_din = 1'b0;
  logic cfg_dout, cfg_clk_out;
  logic [COLS-1:0] north_in = '0, south_in = '0, north_out, south_out;
  logic [ROWS-1:0] east_in = '0, west_in = '0, east_out, west_out;

  int n_cmp = 0, n_bad = 0;
  bit armed = 0;
  logic [L-1:0] model = '0;
  logic [L-1:0] shadow_m = '0;

  always #5 cfg_clk = ~cfg_clk;

  lut_tile #(.COLS(COLS), .ROWS(ROWS)) u_dut (
    .cfg_clk(cfg_clk), .arst(arst), .run(run), .cfg_din(cfg_din),
    .cfg_dout(cfg_dout), .cfg_clk_out(cfg_clk_out),
    .north_in(north_in), .north_out(north_out),
    .south_in(south_in), .south_out(south_out),
    .east_in(east_in), .east_out(east_out),
    .west_in(west_in), .west_out(west_out)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural chain model.
  always @(posedge cfg_clk or posedge arst) begin
    if (arst) model <= '0;
    else      model <= {model[L-2:0], cfg_din};
  end

  function automatic logic tbl_bit(logic [L-1:0] sh, int k, int off, logic [3:0] idx);
    return sh[k*64 + off + int'(idx)];
  endfunction

  // Reference outputs by relaxation (valid for feed-forward configurations).
  function automatic logic [OW-1:0] ref_out(logic [L-1:0] sh, logic rn);
    logic on_[CELLS], oe_[CELLS], os_[CELLS], ow_[CELLS];
    logic [COLS-1:0] no, so;
    logic [ROWS-1:0] eo, wo;
    for (int k = 0; k < CELLS; k++) begin
      on_[k] = 0; oe_[k] = 0; os_[k] = 0; ow_[k] = 0;
    end
    if (!rn) return '0;
    for (int p = 0; p < ROWS + COLS + 2; p++) begin
      for (int r = 0; r < ROWS; r++) begin
        for (int c = 0; c < COLS; c++) begin
          int k = r*COLS + c;
          logic n, e, s, w;
          s = (r == 0)      ? south_in[c] : on_[k-COLS];
          n = (r == ROWS-1) ? north_in[c] : os_[k+COLS];
          w = (c == 0)      ? west_in[r]  : oe_[k-1];
          e = (c == COLS-1) ? east_in[r]  : ow_[k+1];
          on_[k] = tbl_bit(sh, k, 0,  {n, e, s, w});
          oe_[k] = tbl_bit(sh, k, 16, {e, s, w, n});
          os_[k] = tbl_bit(sh, k, 32, {s, w, n, e});
          ow_[k] = tbl_bit(sh, k, 48, {w, n, e, s});
        end
      end
    end
    for (int c = 0; c < COLS; c++) begin
      no[c] = on_[(ROWS-1)*COLS + c];
      so[c] = os_[c];
    end
    for (int r = 0; r < ROWS; r++) begin
      eo[r] = oe_[r*COLS + COLS - 1];
      wo[r] = ow_[r*COLS];
    end
    return {no, so, eo, wo};
  endfunction

  // Compare on every clock, away from the active edge.
  always @(negedge cfg_clk) begin
    if (armed) begin
      if (!run) shadow_m = model;
      chk("R1", 64'(cfg_dout), 64'(model[L-1]));
      chk(run ? "R3" : "R4", 64'({north_out, south_out, east_out, west_out}),
          64'(ref_out(shadow_m, run)));
      chk("R7", 64'(cfg_clk_out), 64'(0));
    end
  end

  task automatic tick();
    @(posedge cfg_clk); #1;
  endtask

  task automatic set_run(logic v);
    if (v) shadow_m = model;
    run = v;
  endtask

  task automatic load(logic [L-1:0] cfg);
    for (int i = L-1; i >= 0; i--) begin
      cfg_din = cfg[i];
      tick();
    end
    cfg_din = 0;
  endtask

  task automatic drive_random(int n);
    for (int i = 0; i < n; i++) begin
      north_in = COLS'($urandom); south_in = COLS'($urandom);
      east_in  = ROWS'($urandom); west_in  = ROWS'($urandom);
      tick();
    end
  endtask

  function automatic logic [15:0] pick4();
    case ($urandom % 4)
      0: return 16'hCCCC;
      1: return 16'h3333;
      2: return 16'h0000;
      default: return 16'hFFFF;
    endcase
  endfunction

  logic [L-1:0] cfg_v;
  logic [OW-1:0] snap;

  initial begin
    #(200000 * 10);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    arst = 0;
    armed = 1;
    tick();
    // R6 reset state
    chk("R6", 64'(cfg_dout), 0);
    chk("R4", 64'({north_out, south_out, east_out, west_out}), 0);
    @(posedge cfg_clk); #2;
    chk("R7", 64'(cfg_clk_out), 64'(1));
    #(-1ps); #1;

    // R9 opposite-copy everywhere
    for (int k = 0; k < CELLS*4; k++) cfg_v[k*16 +: 16] = 16'hCCCC;
    load(cfg_v);
    set_run(1);
    drive_random(6);
    north_in = 3'b101; south_in = 3'b011; east_in = 2'b01; west_in = 2'b10;
    tick();
    chk("R9", 64'(north_out), 64'(south_in));
    chk("R9", 64'(south_out), 64'(north_in));
    chk("R9", 64'(east_out),  64'(west_in));
    chk("R9", 64'(west_out),  64'(east_in));
    // R8 one-hot on one row edge reaches only the same row on the far side
    north_in = 0; south_in = 0; east_in = 0; west_in = 2'b10;
    tick();
    chk("R8", 64'({north_out, south_out, east_out, west_out}), 64'({3'b000, 3'b000, 2'b10, 2'b00}));

    // R5 shifting while running leaves outputs alone
    snap = {north_out, south_out, east_out, west_out};
    for (int i = 0; i < 100; i++) begin
      cfg_din = 1'($urandom);
      tick();
    end
    cfg_din = 0;
    chk("R5", 64'({north_out, south_out, east_out, west_out}), 64'(snap));

    // R4 dropping run zeroes outputs
    set_run(0);
    tick();
    chk("R4", 64'({north_out, south_out, east_out, west_out}), 0);

    // R3 random copy/invert/constant tables
    for (int k = 0; k < CELLS*4; k++) cfg_v[k*16 +: 16] = pick4();
    load(cfg_v);
    set_run(1);
    drive_random(12);
    set_run(0);

    // R3 diagonal: north = S xor W, east = S and W, south/west constant
    for (int k = 0; k < CELLS; k++) begin
      cfg_v[k*64 +: 16]      = 16'h6666;
      cfg_v[k*64 + 16 +: 16] = 16'hC0C0;
      cfg_v[k*64 + 32 +: 16] = ($urandom % 2) ? 16'hFFFF : 16'h0000;
      cfg_v[k*64 + 48 +: 16] = ($urandom % 2) ? 16'hFFFF : 16'h0000;
    end
    load(cfg_v);
    set_run(1);
    drive_random(16);
    set_run(0);

    // R2 marker: only cell (row 1, column 0) has a north table of ones
    cfg_v = '0;
    cfg_v[(1*COLS + 0)*64 +: 16] = 16'hFFFF;
    load(cfg_v);
    set_run(1);
    drive_random(2);
    chk("R2", 64'({north_out, south_out, east_out, west_out}), 64'({3'b001, 3'b000, 2'b00, 2'b00}));
    set_run(0);

    // R1 chain pass-through: ones emerge one full chain length later
    load('1);
    chk("R1", 64'(cfg_dout), 64'(1));

    // R6 asynchronous clear between edges
    @(negedge cfg_clk); #2;
    arst = 1; #1;
    chk("R6", 64'(cfg_dout), 0);
    tick();
    arst = 0;
    tick();
    chk("R6", 64'(cfg_dout), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule